// File: doc/BRIEF.md
# Shared-Buffer Cipher Command Controller

This block is the front end a processor uses to drive a 128-bit block-cipher engine without moving data through registers. Software first stores its plaintext or ciphertext in a 4 KiB shared buffer. It then writes one command word that carries the direction, the buffer half, the starting block and the block count. The controller walks that region one 16-byte block at a time. It reads each block, hands it to the engine over a start/done handshake, and writes the result back to the same address.

The first 16 bytes of the buffer hold the control region. The rest is split into two halves, one per processor: half A covers bytes 0x10 to 0x7FF and half B covers bytes 0x800 to 0xFFF. While a job runs, the processor can do other work. It learns that the job has finished from the done flag or from the one-cycle interrupt. A range that would cross the end of its half is refused, and so is a command written while a job is still running. Both cases raise an error flag.

Top module: `cipher_cmd_ctrl`

## Requirements
- R1: Command word fields: bit 0 selects the direction (0 encrypt, 1 decrypt, driven on `eng_dec_o`), bit 1 selects the half (0 = A, 1 = B), bits [15:8] give the starting block offset within the half, and bits [23:16] give the length in 16-byte blocks. The other bits are ignored.
- R2: `buf_addr_o` is a block index (byte offset / 16). Half A has base block 1 and holds 127 blocks. Half B has base block 128 and holds 128 blocks. Block i of a job is at base + offset + i, and the controller never accesses block 0.
- R3: Each block is read once and passed to the engine with exactly one single-cycle start. The engine result is written to the same block index. Blocks are handled in ascending order, and no other buffer location is written.
- R4: The cycle after an accepted command, busy is high. Each block then takes four controller cycles plus the number of cycles from the end of the start cycle to the cycle in which `eng_done_i` is high.
- R5: In the cycle where busy falls, done rises, and the interrupt is high for exactly that one cycle.
- R6: A zero-length command raises done and the interrupt in the next cycle. It never raises busy and makes no buffer access.
- R7: A command with offset + length greater than the size of its half is refused. The next cycle shows error = 1, done = 0 and busy = 0, and no buffer access follows.
- R8: A command written while busy is ignored and sets error. The running job goes on with unchanged timing and data.
- R9: Writing a command while idle clears done. A command that is not refused also clears error.
- R10: After reset, busy, done, error, interrupt, buffer request and engine start are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command word write strobe |
| cmd_wdata | input | 32 | Command word |
| busy_o | output | 1 | Job in progress |
| done_o | output | 1 | Last job finished (sticky until next command) |
| err_o | output | 1 | Last command refused or written while busy |
| irq_o | output | 1 | One-cycle completion pulse |
| buf_req_o | output | 1 | Buffer access request |
| buf_we_o | output | 1 | Buffer write (1) or read (0) |
| buf_addr_o | output | 8 | Buffer block index |
| buf_wdata_o | output | 128 | Block written back |
| buf_rdata_i | input | 128 | Read data, valid the cycle after a read request |
| eng_start_o | output | 1 | Engine start pulse |
| eng_dec_o | output | 1 | Engine direction, 1 = decrypt |
| eng_din_o | output | 128 | Block to the engine |
| eng_done_i | input | 1 | Engine result valid |
| eng_dout_i | input | 128 | Engine result |

## Verification
The engine model answers in the second cycle after each start pulse, so every block costs six cycles. The bench counts busy cycles after each accepted command and expects exactly six per block. It also expects done and the interrupt at the sample where busy first reads low, and the interrupt gone one sample later. Refused and zero-length commands are checked at the first sample after the write edge. Every write-back is compared, in order, against a queue the driver fills before issuing the command.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RD,
        S_CAP,
        S_GO,
        S_WT,
        S_WR
    } seq_st_e;

    localparam int FLD_W = 8;
endpackage

// File: rtl/ccc_cmd_check.sv
module ccc_cmd_check #(
    parameter int BUF_BLOCKS  = 256,
    parameter int CTRL_BLOCKS = 1,
    parameter int IDX_W       = $clog2(BUF_BLOCKS),
    parameter int FLD_W       = 8
) (
    input  logic [31:0]      cmd,
    output logic             dec,
    output logic [IDX_W-1:0] first_blk,
    output logic [FLD_W-1:0] nblk,
    output logic             fits,
    output logic             zero
);
    localparam int HALF  = BUF_BLOCKS / 2;
    localparam int SUM_W = IDX_W + 2;

    logic             half_b;
    logic [FLD_W-1:0] off;
    logic [SUM_W-1:0] end_blk, room;
    logic             unused_bits;

    always_comb begin
        dec       = cmd[0];
        half_b    = cmd[1];
        off       = cmd[8 +: FLD_W];
        nblk      = cmd[16 +: FLD_W];
        end_blk   = SUM_W'(off) + SUM_W'(nblk);
        room      = half_b ? SUM_W'(HALF) : SUM_W'(HALF - CTRL_BLOCKS);
        fits      = (end_blk <= room);
        zero      = (nblk == '0);
        first_blk = (half_b ? IDX_W'(HALF) : IDX_W'(CTRL_BLOCKS)) + IDX_W'(off);
    end

    assign unused_bits = ^{cmd[31:24], cmd[7:2]};
endmodule

// File: rtl/ccc_blk_seq.sv
module ccc_blk_seq
    import ccc_pkg::*;
#(
    parameter int IDX_W       = 8,
    parameter int DATA_W      = 128,
    parameter int CTRL_BLOCKS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              dec_i,
    input  logic [IDX_W-1:0]  first_i,
    input  logic [FLD_W-1:0]  nblk_i,
    output logic              busy,
    output logic              fin,
    output logic              buf_req,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_addr,
    output logic [DATA_W-1:0] buf_wdata,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              eng_start,
    output logic              eng_dec,
    output logic [DATA_W-1:0] eng_din,
    input  logic              eng_done,
    input  logic [DATA_W-1:0] eng_dout
);
    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  addr;
        logic [FLD_W-1:0]  left;
        logic              dec;
        logic [DATA_W-1:0] data;
    } seq_t;

    seq_t sq_q, sq_d;

    always_comb begin
        sq_d      = sq_q;
        fin       = 1'b0;
        buf_req   = 1'b0;
        buf_we    = 1'b0;
        eng_start = 1'b0;
        unique case (sq_q.st)
            S_IDLE: if (launch) begin
                sq_d.st   = S_RD;
                sq_d.addr = first_i;
                sq_d.left = nblk_i;
                sq_d.dec  = dec_i;
            end
            S_RD: begin
                buf_req = 1'b1;
                sq_d.st = S_CAP;
            end
            S_CAP: begin
                sq_d.data = buf_rdata;
                sq_d.st   = S_GO;
            end
            S_GO: begin
                eng_start = 1'b1;
                sq_d.st   = S_WT;
            end
            S_WT: if (eng_done) begin
                sq_d.data = eng_dout;
                sq_d.st   = S_WR;
            end
            S_WR: begin
                buf_req   = 1'b1;
                buf_we    = 1'b1;
                sq_d.addr = sq_q.addr + 1'b1;
                sq_d.left = sq_q.left - 1'b1;
                if (sq_q.left == FLD_W'(1)) begin
                    sq_d.st = S_IDLE;
                    fin     = 1'b1;
                end else begin
                    sq_d.st = S_RD;
                end
            end
            default: sq_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_q    <= '0;
            sq_q.st <= S_IDLE;
        end else begin
            sq_q <= sq_d;
        end
    end

    assign busy      = (sq_q.st != S_IDLE);
    assign buf_addr  = sq_q.addr;
    assign buf_wdata = sq_q.data;
    assign eng_din   = sq_q.data;
    assign eng_dec   = sq_q.dec;

    // R3
    start_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R2
    ctrl_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_req |-> (buf_addr >= IDX_W'(CTRL_BLOCKS)));

    // R8
    launch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch |-> !busy);
endmodule

// File: rtl/ccc_status.sv
module ccc_status (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_we,
    input  logic busy,
    input  logic fits,
    input  logic zero,
    input  logic fin,
    output logic launch,
    output logic done,
    output logic err,
    output logic irq
);
    typedef struct packed {
        logic done;
        logic err;
        logic irq;
    } stat_t;

    stat_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        launch   = cmd_we && !busy && !zero && fits;
        if (fin) begin
            st_d.done = 1'b1;
            st_d.irq  = 1'b1;
        end
        if (cmd_we) begin
            if (busy) begin
                st_d.err = 1'b1;
            end else begin
                st_d.err  = !zero && !fits;
                st_d.done = zero;
                st_d.irq  = zero;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done = st_q.done;
    assign err  = st_q.err;
    assign irq  = st_q.irq;

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && zero) |=> (done && irq && !busy));

    // R9
    cmd_clears_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !zero) |=> !done);

    // R7
    refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && !busy && !zero && !fits) |=> (err && !busy));
endmodule

// File: rtl/cipher_cmd_ctrl.sv
module cipher_cmd_ctrl
    import ccc_pkg::*;
#(
    parameter int BUF_BLOCKS  = 256,
    parameter int CTRL_BLOCKS = 1,
    parameter int DATA_W      = 128,
    parameter int IDX_W       = $clog2(BUF_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [31:0]       cmd_wdata,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o,
    output logic              irq_o,
    output logic              buf_req_o,
    output logic              buf_we_o,
    output logic [IDX_W-1:0]  buf_addr_o,
    output logic [DATA_W-1:0] buf_wdata_o,
    input  logic [DATA_W-1:0] buf_rdata_i,
    output logic              eng_start_o,
    output logic              eng_dec_o,
    output logic [DATA_W-1:0] eng_din_o,
    input  logic              eng_done_i,
    input  logic [DATA_W-1:0] eng_dout_i
);
    logic             c_dec, c_fits, c_zero, launch, fin;
    logic [IDX_W-1:0] c_first;
    logic [FLD_W-1:0] c_nblk;

    ccc_cmd_check #(
        .BUF_BLOCKS(BUF_BLOCKS), .CTRL_BLOCKS(CTRL_BLOCKS),
        .IDX_W(IDX_W), .FLD_W(FLD_W)
    ) u_chk (
        .cmd(cmd_wdata), .dec(c_dec), .first_blk(c_first),
        .nblk(c_nblk), .fits(c_fits), .zero(c_zero)
    );

    ccc_status u_stat (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .busy(busy_o),
        .fits(c_fits), .zero(c_zero), .fin(fin), .launch(launch),
        .done(done_o), .err(err_o), .irq(irq_o)
    );

    ccc_blk_seq #(
        .IDX_W(IDX_W), .DATA_W(DATA_W), .CTRL_BLOCKS(CTRL_BLOCKS)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .dec_i(c_dec),
        .first_i(c_first), .nblk_i(c_nblk), .busy(busy_o), .fin(fin),
        .buf_req(buf_req_o), .buf_we(buf_we_o), .buf_addr(buf_addr_o),
        .buf_wdata(buf_wdata_o), .buf_rdata(buf_rdata_i),
        .eng_start(eng_start_o), .eng_dec(eng_dec_o), .eng_din(eng_din_o),
        .eng_done(eng_done_i), .eng_dout(eng_dout_i)
    );

    // R5
    busy_fall_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (done_o && irq_o));
endmodule

// File: tb/cipher_cmd_ctrl_test.sv
module cipher_cmd_ctrl_test;
    localparam logic [127:0] KEY = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
    localparam int BPB = 6; // cycles per block with this engine model

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_we = 1'b0;
    logic [31:0]  cmd_wdata = '0;
    logic         busy_o, done_o, err_o, irq_o;
    logic         buf_req_o, buf_we_o;
    logic [7:0]   buf_addr_o;
    logic [127:0] buf_wdata_o, buf_rdata_i, eng_din_o, eng_dout_i;
    logic         eng_start_o, eng_dec_o, eng_done_i;

    int total = 0;
    int bad = 0;

    logic [127:0] bmem [256];
    logic [127:0] mdl  [256];
    logic [127:0] orig [256];
    logic [7:0]   qa[$];
    logic [127:0] qd[$];
    logic [127:0] e_din;
    logic         e_dec;

    always #4 clk = ~clk;

    cipher_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
        .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .irq_o(irq_o),
        .buf_req_o(buf_req_o), .buf_we_o(buf_we_o), .buf_addr_o(buf_addr_o),
        .buf_wdata_o(buf_wdata_o), .buf_rdata_i(buf_rdata_i),
        .eng_start_o(eng_start_o), .eng_dec_o(eng_dec_o), .eng_din_o(eng_din_o),
        .eng_done_i(eng_done_i), .eng_dout_i(eng_dout_i)
    );

    function automatic logic [127:0] f_enc(input logic [127:0] d);
        return {d[119:0], d[127:120]} ^ KEY;
    endfunction
    function automatic logic [127:0] f_dec(input logic [127:0] d);
        logic [127:0] t;
        t = d ^ KEY;
        return {t[7:0], t[127:8]};
    endfunction

    task automatic chk(input bit ok, input string rq,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    // buffer memory: one-cycle read latency
    always @(posedge clk) begin
        if (buf_req_o) begin
            if (buf_we_o) bmem[buf_addr_o] <= buf_wdata_o;
            else          buf_rdata_i     <= bmem[buf_addr_o];
        end
    end

    // engine model: result in the second cycle after the start cycle
    initial begin
        eng_done_i = 1'b0;
        eng_dout_i = '0;
        forever begin
            @(negedge clk);
            if (eng_start_o) begin
                e_din = eng_din_o;
                e_dec = eng_dec_o;
                @(negedge clk);
                @(negedge clk);
                eng_done_i = 1'b1;
                eng_dout_i = e_dec ? f_dec(e_din) : f_enc(e_din);
                @(negedge clk);
                eng_done_i = 1'b0;
            end
        end
    end

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && buf_req_o) begin
            if (qa.size() == 0) begin
                chk(1'b0, "R7 unexpected buffer access", {120'd0, buf_addr_o}, 128'd0);
            end else if (buf_we_o) begin
                chk(buf_addr_o == qa[0], "R3 write address", {120'd0, buf_addr_o}, {120'd0, qa[0]});
                chk(buf_wdata_o == qd[0], "R3 write data", buf_wdata_o, qd[0]);
                void'(qa.pop_front());
                void'(qd.pop_front());
            end else begin
                chk(buf_addr_o == qa[0], "R2 read address", {120'd0, buf_addr_o}, {120'd0, qa[0]});
            end
        end
    end

    function automatic logic [31:0] mkcmd(input bit dec, input bit hb,
                                          input int off, input int len);
        return {8'h00, 8'(len), 8'(off), 6'h15, hb, dec}; // R1: bits 7:2 ignored
    endfunction

    task automatic send_cmd(input logic [31:0] w);
        @(negedge clk);
        cmd_we    = 1'b1;
        cmd_wdata = w;
        @(negedge clk);
        cmd_we    = 1'b0;
    endtask

    task automatic run_job(input bit dec, input bit hb, input int off,
                           input int len, input bit intr);
        int base, cnt;
        base = hb ? 128 : 1;
        for (int i = 0; i < len; i++) begin
            int a = base + off + i;
            mdl[a] = dec ? f_dec(mdl[a]) : f_enc(mdl[a]);
            qa.push_back(8'(a));
            qd.push_back(mdl[a]);
        end
        send_cmd(mkcmd(dec, hb, off, len));
        chk(busy_o == 1'b1, "R4 busy after accept", {127'd0, busy_o}, 128'd1);
        chk(done_o == 1'b0, "R9 done cleared", {127'd0, done_o}, 128'd0);
        chk(err_o == 1'b0, "R9 err cleared", {127'd0, err_o}, 128'd0);
        cnt = 0;
        while (busy_o && cnt < 5000) begin
            cnt++;
            if (intr && cnt == 3) begin
                cmd_we    = 1'b1;
                cmd_wdata = mkcmd(1'b0, 1'b0, 0, 2);
            end
            if (intr && cnt == 4) begin
                cmd_we = 1'b0;
                chk(err_o == 1'b1, "R8 err on busy write", {127'd0, err_o}, 128'd1);
            end
            @(negedge clk);
        end
        chk(cnt == BPB * len, "R4 job cycles", 128'(cnt), 128'(BPB * len));
        chk(done_o == 1'b1, "R5 done at busy fall", {127'd0, done_o}, 128'd1);
        chk(irq_o == 1'b1, "R5 irq at busy fall", {127'd0, irq_o}, 128'd1);
        chk(qa.size() == 0, "R3 all blocks written", 128'(qa.size()), 128'd0);
        @(negedge clk);
        chk(irq_o == 1'b0, "R5 irq one cycle", {127'd0, irq_o}, 128'd0);
    endtask

    task automatic refuse(input bit hb, input int off, input int len);
        send_cmd(mkcmd(1'b0, hb, off, len));
        chk(err_o == 1'b1, "R7 err on refuse", {127'd0, err_o}, 128'd1);
        chk(done_o == 1'b0, "R7 done low", {127'd0, done_o}, 128'd0);
        chk(busy_o == 1'b0, "R7 busy low", {127'd0, busy_o}, 128'd0);
        repeat (10) @(negedge clk);
        chk(busy_o == 1'b0, "R7 stays idle", {127'd0, busy_o}, 128'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            logic [31:0] s;
            s = 32'(i) * 32'h9e3779b1;
            bmem[i] = {s, ~s, s ^ 32'h5a5a5a5a, s + 32'd7};
            mdl[i]  = bmem[i];
            orig[i] = bmem[i];
        end
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({busy_o, done_o, err_o, irq_o, buf_req_o, eng_start_o} == 6'b0,
            "R10 reset outputs",
            {122'd0, busy_o, done_o, err_o, irq_o, buf_req_o, eng_start_o}, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        run_job(1'b0, 1'b0, 0, 3, 1'b0);     // R1 R2 encrypt, half A start
        run_job(1'b1, 1'b0, 0, 3, 1'b0);     // R1 decrypt restores
        for (int i = 1; i < 4; i++)
            chk(bmem[i] == orig[i], "R1 decrypt inverse", bmem[i], orig[i]);
        run_job(1'b0, 1'b1, 120, 8, 1'b0);   // R2 half B up to its last block
        run_job(1'b1, 1'b0, 126, 1, 1'b0);   // R2 half A last block
        refuse(1'b0, 126, 2);                // R7 crosses end of half A
        refuse(1'b1, 127, 2);                // R7 crosses end of half B

        // R6 zero length, R9 clears err
        send_cmd(mkcmd(1'b0, 1'b1, 5, 0));
        chk(done_o == 1'b1, "R6 done next cycle", {127'd0, done_o}, 128'd1);
        chk(irq_o == 1'b1, "R6 irq next cycle", {127'd0, irq_o}, 128'd1);
        chk(busy_o == 1'b0, "R6 no busy", {127'd0, busy_o}, 128'd0);
        chk(err_o == 1'b0, "R9 err cleared by zero cmd", {127'd0, err_o}, 128'd0);
        repeat (5) @(negedge clk);

        // R8 command while busy is ignored
        run_job(1'b0, 1'b1, 0, 4, 1'b1);
        chk(err_o == 1'b1, "R8 err kept after job", {127'd0, err_o}, 128'd1);

        // R9 any idle command clears done
        refuse(1'b0, 127, 1);
        run_job(1'b1, 1'b1, 0, 2, 1'b0);

        for (int i = 0; i < 256; i++)
            chk(bmem[i] == mdl[i], "R3 buffer image", bmem[i], mdl[i]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule